// File: doc/BRIEF.md
# Bus Cycle Ready Generator

This block decides when the current microprocessor bus cycle may end and drives the active-low termination line for it. Two ready sources feed it. The synchronous source must meet setup time at the falling clock edge. The asynchronous source arrives with no fixed timing and is first passed through a two-stage synchronizer. Each source has its own active-low enable, so an address decoder can pick which source ends the cycle. The two active-low bus status lines mark the start of a new cycle. The half-rate peripheral clock phase, taken as an input, sets which falling edges may sample a ready source.

The block also produces the system reset. An active-low reset request, which may change at any time, is synchronized into an active-high reset output. While that reset is active the block holds the ready line asserted. The termination pin is open-collector, so it is modelled as a drive-low enable. A resolved line is also provided that behaves as if an external pull-up were fitted. All state changes on the falling edge of the bus clock.

Top module: `bus_ready_gen`

## Requirements
- R1: A ready source counts only when its ready line and its enable line are both low (0). One low line alone, with its partner high, never asserts ready.
- R2: The synchronous pair is sampled only at a falling edge where both status lines are high (1) and the phase input is high (1). When the pair is active at that edge, `rdy_pull_low` becomes 1 at that same edge. With the phase input low, or with either status line low, the pair has no effect.
- R3: The asynchronous pair passes through a two-stage falling-edge synchronizer. A pair that is held active asserts ready at the third falling edge after it is applied, provided the phase input is high at that edge. This happens while the synchronous pair is inactive.
- R4: Once asserted, ready holds through edges where the phase input is low. It is released only when a status line is low, or when an edge with the phase input high samples both pairs inactive.
- R5: Ready stays asserted for at least two falling edges after it rises. The only exceptions are a status line sampled low or an active reset.
- R6: A falling edge that samples either status line low sets `rdy_pull_low` to 0 at that edge, so the ready line floats.
- R7: `sys_reset` becomes 1 at the second falling edge after `rst_req_n` goes low. It returns to 0 at the second falling edge after `rst_req_n` goes high.
- R8: While `sys_reset` is 1, `rdy_pull_low` is 1 from the next falling edge onward. This holds even when a status line is low.
- R9: `rdy_n` equals the inverse of `rdy_pull_low`, which models the line as resolved through a pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; all state updates on its falling edge |
| rst_req_n | input | 1 | Active-low reset request, asynchronous |
| stat0_n | input | 1 | Bus status line 0, active low |
| stat1_n | input | 1 | Bus status line 1, active low |
| pclk_phase | input | 1 | Half-rate peripheral clock level; high enables ready sampling |
| sync_rdy_n | input | 1 | Synchronous ready, active low |
| sync_en_n | input | 1 | Enable for synchronous ready, active low |
| async_rdy_n | input | 1 | Asynchronous ready, active low |
| async_en_n | input | 1 | Enable for asynchronous ready, active low |
| sys_reset | output | 1 | Synchronized system reset, active high |
| rdy_pull_low | output | 1 | Open-collector drive enable for the ready line |
| rdy_n | output | 1 | Resolved ready line with pull-up, active low |

## Verification
The synchronous pair is applied under four conditions: with the phase input low, with a status line low, with only the line low, and with only the enable low. These separate the sampling gate from the two-low qualification. A one-edge synchronous pulse shows that the minimum hold time governs release. A held pair shows that release comes from a status line. A held asynchronous pulse is used to measure the synchronizer latency, and to show that ready holds across a low phase and then drops once the synchronized value goes inactive. Reset is asserted in the middle of operation with a status line low. This sets apart the reset override and its one-edge lag from the normal release path.

// File: rtl/bus_ready_pkg.sv
package bus_ready_pkg;

    // which source won the sampling decision at an edge
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SYNC  = 2'd1,
        SRC_ASYNC = 2'd2
    } rdy_src_e;

    // a ready source counts only when line and enable are both low
    function automatic logic pair_on(input logic line_n, input logic en_n);
        return (!line_n) && (!en_n);
    endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_comb begin
                stage_d[s] = stage_q[s-1];
            end
        end
    endgenerate

    always_ff @(negedge clk) begin
        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/reset_path.sv
module reset_path #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic req_n,
    output logic reset_act
);
    logic req_sync;

    edge_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
        .clk  (clk),
        .din  (req_n),
        .dout (req_sync)
    );

    assign reset_act = !req_sync;

    // R7: request low on an edge gives reset two edges later, and back
    assert_reset_assert_R7: assert property (@(negedge clk)
        !req_n |-> ##2 reset_act);
    assert_reset_release_R7: assert property (@(negedge clk)
        req_n |-> ##2 !reset_act);
endmodule

// File: rtl/ready_core.sv
module ready_core
    import bus_ready_pkg::*;
#(
    parameter int MIN_HOLD = 2
) (
    input  logic clk,
    input  logic rst_now,
    input  logic stat0_n,
    input  logic stat1_n,
    input  logic phase_hi,
    input  logic sync_on,
    input  logic async_on,
    output logic drive_low
);
    localparam int CNT_W = $clog2(MIN_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_MAX = CNT_W'(MIN_HOLD);

    typedef struct packed {
        logic             drive;
        logic [CNT_W-1:0] held;
    } core_state_t;

    core_state_t st_d, st_q;
    rdy_src_e    src_d;
    logic        stat_idle;

    assign stat_idle = stat0_n && stat1_n;

    always_comb begin
        st_d  = st_q;
        src_d = SRC_NONE;
        if (rst_now) begin
            st_d.drive = 1'b1;
            st_d.held  = HOLD_MAX;
        end else if (!stat_idle) begin
            st_d.drive = 1'b0;
            st_d.held  = '0;
        end else begin
            if (phase_hi) begin
                if (async_on) begin
                    src_d = SRC_ASYNC;
                end else if (sync_on) begin
                    src_d = SRC_SYNC;
                end
                if (src_d != SRC_NONE) begin
                    st_d.drive = 1'b1;
                end else if (st_q.drive && (st_q.held >= HOLD_MAX)) begin
                    st_d.drive = 1'b0;
                end
            end
            if (!st_d.drive) begin
                st_d.held = '0;
            end else if (!st_q.drive) begin
                st_d.held = CNT_W'(1);
            end else if (st_q.held < HOLD_MAX) begin
                st_d.held = st_q.held + CNT_W'(1);
            end
        end
    end

    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign drive_low = st_q.drive;

    // R6: a status line sampled low floats ready at that edge
    assert_status_release_R6: assert property (@(negedge clk) disable iff (rst_now)
        (!stat0_n || !stat1_n) |=> !drive_low);
    // R2: qualified synchronous ready asserts at the sampling edge
    assert_sync_take_R2: assert property (@(negedge clk) disable iff (rst_now)
        (stat_idle && phase_hi && sync_on) |=> drive_low);
    // R5: a fresh assertion survives the next edge unless a status line is low
    assert_min_hold_R5: assert property (@(negedge clk) disable iff (rst_now)
        ($rose(drive_low) && stat_idle) |=> drive_low);
    // R8: active reset forces ready one edge later
    assert_reset_forces_R8: assert property (@(negedge clk)
        rst_now |=> drive_low);
endmodule

// File: rtl/bus_ready_gen.sv
module bus_ready_gen
    import bus_ready_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HOLD    = 2
) (
    input  logic bus_clk,
    input  logic rst_req_n,
    input  logic stat0_n,
    input  logic stat1_n,
    input  logic pclk_phase,
    input  logic sync_rdy_n,
    input  logic sync_en_n,
    input  logic async_rdy_n,
    input  logic async_en_n,
    output logic sys_reset,
    output logic rdy_pull_low,
    output logic rdy_n
);
    logic [1:0] async_raw;
    logic [1:0] async_syn;
    logic       async_on;
    logic       sync_on;

    assign async_raw = {async_rdy_n, async_en_n};

    edge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_async_sync (
        .clk  (bus_clk),
        .din  (async_raw),
        .dout (async_syn)
    );

    reset_path #(.STAGES(SYNC_STAGES)) u_reset (
        .clk       (bus_clk),
        .req_n     (rst_req_n),
        .reset_act (sys_reset)
    );

    assign async_on = pair_on(async_syn[1], async_syn[0]);
    assign sync_on  = pair_on(sync_rdy_n, sync_en_n);

    ready_core #(.MIN_HOLD(MIN_HOLD)) u_core (
        .clk       (bus_clk),
        .rst_now   (sys_reset),
        .stat0_n   (stat0_n),
        .stat1_n   (stat1_n),
        .phase_hi  (pclk_phase),
        .sync_on   (sync_on),
        .async_on  (async_on),
        .drive_low (rdy_pull_low)
    );

    // pull-up resolution of the open-collector line
    assign rdy_n = !rdy_pull_low;
endmodule

// File: tb/bus_ready_gen_tb_top.sv
module bus_ready_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // bits: {stat1_n, stat0_n, phase, sync_rdy_n, sync_en_n, async_rdy_n, async_en_n, expected drive}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b11111110, // 0 idle
        8'b11100111, // 1 sync pair taken R2
        8'b11111111, // 2 held by minimum time R5
        8'b11111110, // 3 released after inputs inactive R4
        8'b11000110, // 4 phase low, no sample R2
        8'b11101110, // 5 line only R1
        8'b11110110, // 6 enable only R1
        8'b10100110, // 7 status low blocks sampling R2
        8'b11100111, // 8 sync taken
        8'b11100111, // 9 held while active R4
        8'b01100110, // 10 status low floats R6
        8'b11111000, // 11 async stage 1 R3
        8'b11111000, // 12 async stage 2 R3
        8'b11111001, // 13 async taken R3
        8'b11011111, // 14 phase low holds R4
        8'b11111111, // 15 synchronizer still active R3
        8'b11111110  // 16 released R4
    };

    logic bus_clk = 1'b0;
    logic rst_req_n = 1'b0;
    logic stat0_n = 1'b1, stat1_n = 1'b1, pclk_phase = 1'b1;
    logic sync_rdy_n = 1'b1, sync_en_n = 1'b1, async_rdy_n = 1'b1, async_en_n = 1'b1;
    logic sys_reset, rdy_pull_low, rdy_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;

    bus_ready_gen dut_i (
        .bus_clk      (bus_clk),
        .rst_req_n    (rst_req_n),
        .stat0_n      (stat0_n),
        .stat1_n      (stat1_n),
        .pclk_phase   (pclk_phase),
        .sync_rdy_n   (sync_rdy_n),
        .sync_en_n    (sync_en_n),
        .async_rdy_n  (async_rdy_n),
        .async_en_n   (async_en_n),
        .sys_reset    (sys_reset),
        .rdy_pull_low (rdy_pull_low),
        .rdy_n        (rdy_n)
    );

    task automatic tick();
        @(negedge bus_clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            1, 4, 7, 8:         return "R2";
            2:                  return "R5";
            3, 9, 14, 16:       return "R4";
            5, 6:               return "R1";
            10:                 return "R6";
            11, 12, 13, 15:     return "R3";
            default:            return "R1";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state
        repeat (4) tick();
        chk("R7 reset active", sys_reset, 1'b1);
        chk("R8 ready forced in reset", rdy_pull_low, 1'b1);
        chk("R9 resolved line", rdy_n, 1'b0);

        // release reset: two edges of latency
        rst_req_n = 1'b1;
        tick();
        chk("R7 release edge 1", sys_reset, 1'b1);
        tick();
        chk("R7 release edge 2", sys_reset, 1'b0);
        chk("R8 ready one edge after reset", rdy_pull_low, 1'b1);
        tick();
        chk("R4 ready released after reset", rdy_pull_low, 1'b0);
        chk("R9 resolved line idle", rdy_n, 1'b1);

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            {stat1_n, stat0_n, pclk_phase, sync_rdy_n, sync_en_n, async_rdy_n, async_en_n} = VEC[i][7:1];
            tick();
            chk(vec_tag(i), rdy_pull_low, VEC[i][0]);
            chk("R9 resolved line", rdy_n, !VEC[i][0]);
        end

        // mid-operation reset with a status line low
        stat0_n = 1'b1; stat1_n = 1'b0; pclk_phase = 1'b1;
        sync_rdy_n = 1'b1; sync_en_n = 1'b1; async_rdy_n = 1'b1; async_en_n = 1'b1;
        rst_req_n = 1'b0;
        tick();
        chk("R7 assert edge 1", sys_reset, 1'b0);
        chk("R6 status low floats", rdy_pull_low, 1'b0);
        tick();
        chk("R7 assert edge 2", sys_reset, 1'b1);
        chk("R8 lag of one edge", rdy_pull_low, 1'b0);
        tick();
        chk("R8 reset overrides status", rdy_pull_low, 1'b1);

        rst_req_n = 1'b1; stat1_n = 1'b1;
        tick();
        chk("R7 release edge 1 again", sys_reset, 1'b1);
        tick();
        chk("R7 release edge 2 again", sys_reset, 1'b0);
        tick();
        chk("R4 ready released", rdy_pull_low, 1'b0);

        // sync pair held, then status low ends it
        sync_rdy_n = 1'b0; sync_en_n = 1'b0;
        tick();
        chk("R2 sync taken after reset", rdy_pull_low, 1'b1);
        stat0_n = 1'b0;
        tick();
        chk("R6 release on status 0", rdy_pull_low, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule